// File: doc/BRIEF.md
# OTG Session Request Sequencer

This block runs the device side of the session request protocol for an OTG B-device. When software sets the OTG control bit, the sequencer first waits until the bus is idle. Idle means an SE0 on both data lines while VBUS sits below the session-end threshold, held over a programmable number of millisecond ticks. It then drives the D+ pull-up for a programmable data-line pulse. After that it drives the VBUS charge control for a programmable VBUS pulse. Last, it waits a bounded time for the B-session-valid comparator to rise. The outcome is kept in two flags: success and failure. Both flags clear when the next request starts.

A sticky B-session-valid status bit sits next to the sequencer. Software clears it by writing 1, but the comparator sets it again while the session is still valid. The block also produces the bus-reset indication. With the OTG bit clear, this indication passes the normal bus-reset detector through, one cycle late. With the OTG bit set, it ignores that detector and instead fires once for each SE0 that lasts the programmed number of millisecond ticks. The default for that count is 2.

Top module: `srp_seq_top`

## Requirements
- R1: A 0-to-1 change of `otg_bit` while idle starts a request, and `srp_busy` is 1 from the next cycle until the request ends.
- R2: Before any pulse, the sequencer needs SE0 (`dp_hi`=0 and `dm_hi`=0) together with `sess_end`=1 on INIT_TICKS consecutive ticks. Any cycle in which this condition does not hold restarts that count.
- R3: The D+ pull-up control `pullup_en` is 1 for exactly DP_TICKS ticks, starting the cycle after the initial check is complete.
- R4: `vbus_pulse` rises in the cycle after `pullup_en` falls and stays 1 for VB_TICKS ticks. The two pulses never overlap.
- R5: If `bsess_vld` is 1 in any cycle of the wait phase, `srp_done` is set and the sequencer returns to idle.
- R6: If TO_TICKS ticks pass in the wait phase with no valid session, `srp_fail` is set and the sequencer returns to idle. Both outcome flags clear when a new request starts.
- R7: `bsess_stat` becomes 1 after any cycle with `bsess_vld`=1, and holds until a `bsess_clr` pulse clears it. If `bsess_clr` and `bsess_vld` occur in the same cycle, the bit stays 1.
- R8: While `otg_bit`=0, `brst_ind` equals `bus_rst_det` delayed by one cycle.
- R9: While `otg_bit`=1, `bus_rst_det` is ignored. `brst_ind` pulses for one cycle when SE0 has been present over SE0_TICKS ticks, and pulses only once for each unbroken SE0.
- R10: Clearing `otg_bit` during a request returns the sequencer to idle in the next cycle, with both pulses off and the outcome flags unchanged.
- R11: While `rst` is high, and in the cycle after it is released, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| otg_bit | input | 1 | OTG control bit from the register file |
| bsess_clr | input | 1 | Write-1 pulse that clears the session status |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| dp_hi | input | 1 | Sampled D+ line state |
| dm_hi | input | 1 | Sampled D- line state |
| sess_end | input | 1 | VBUS is below the session-end threshold |
| bsess_vld | input | 1 | B-session-valid comparator output |
| bus_rst_det | input | 1 | Normal bus-reset detector pulse |
| pullup_en | output | 1 | D+ pull-up drive (data-line pulse) |
| vbus_pulse | output | 1 | VBUS charge drive |
| srp_busy | output | 1 | Request in progress |
| srp_done | output | 1 | Last request succeeded |
| srp_fail | output | 1 | Last request timed out |
| bsess_stat | output | 1 | Sticky B-session-valid status |
| brst_ind | output | 1 | Bus-reset indication |

## Verification
Two pairs of events can land in the same cycle. The first pair is a software clear of the session status and an active session-valid comparator. The bench raises `bsess_clr` and `bsess_vld` together and expects the status to remain 1. The second pair is the normal bus-reset detector and an OTG SE0 timeout. The bench pulses `bus_rst_det` during a long SE0 while the OTG bit is set, and expects only the SE0 firing to reach `brst_ind`. A behavioural model tracks both pairs, and the bench compares it with every output on every clock.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CHECK,
        SQ_DPULSE,
        SQ_VPULSE,
        SQ_AWAIT
    } sq_state_e;

    typedef struct packed {
        logic done;
        logic fail;
    } sq_result_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned top);
        return (top < 2) ? 1 : $clog2(top + 1);
    endfunction

endpackage

// File: rtl/srp_fsm.sv
module srp_fsm
    import srp_pkg::*;
#(
    parameter int unsigned INIT_TICKS = 2,
    parameter int unsigned DP_TICKS   = 5,
    parameter int unsigned VB_TICKS   = 10,
    parameter int unsigned TO_TICKS   = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       otg_bit,
    input  logic       ms_tick,
    input  logic       line_se0,
    input  logic       sess_end,
    input  logic       bsess_vld,
    output sq_state_e  state,
    output sq_result_t result
);

    localparam int unsigned MAXT = max2(max2(INIT_TICKS, DP_TICKS), max2(VB_TICKS, TO_TICKS));
    localparam int unsigned CW   = cnt_width(MAXT);

    logic [CW-1:0] cnt;
    logic          otg_q;
    logic          start;
    logic          idle_ok;

    assign start   = otg_bit && !otg_q;
    assign idle_ok = line_se0 && sess_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            cnt    <= '0;
            otg_q  <= 1'b0;
            result <= '0;
        end else begin
            otg_q <= otg_bit;
            if (state != SQ_IDLE && !otg_bit) begin
                state <= SQ_IDLE;
                cnt   <= '0;
            end else begin
                unique case (state)
                    SQ_IDLE: if (start) begin
                        state  <= SQ_CHECK;
                        cnt    <= '0;
                        result <= '0;
                    end
                    SQ_CHECK: begin
                        if (!idle_ok) begin
                            cnt <= '0;
                        end else if (ms_tick) begin
                            if (cnt == CW'(INIT_TICKS - 1)) begin
                                state <= SQ_DPULSE;
                                cnt   <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    SQ_DPULSE: if (ms_tick) begin
                        if (cnt == CW'(DP_TICKS - 1)) begin
                            state <= SQ_VPULSE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SQ_VPULSE: if (ms_tick) begin
                        if (cnt == CW'(VB_TICKS - 1)) begin
                            state <= SQ_AWAIT;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SQ_AWAIT: begin
                        if (bsess_vld) begin
                            state       <= SQ_IDLE;
                            result.done <= 1'b1;
                        end else if (ms_tick) begin
                            if (cnt == CW'(TO_TICKS - 1)) begin
                                state       <= SQ_IDLE;
                                result.fail <= 1'b1;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/srp_sess_stat.sv
module srp_sess_stat (
    input  logic clk,
    input  logic rst,
    input  logic bsess_vld,
    input  logic bsess_clr,
    output logic bsess_stat
);

    always_ff @(posedge clk) begin
        if (rst)
            bsess_stat <= 1'b0;
        else if (bsess_vld)
            bsess_stat <= 1'b1;
        else if (bsess_clr)
            bsess_stat <= 1'b0;
    end

endmodule

// File: rtl/srp_se0_watch.sv
module srp_se0_watch
    import srp_pkg::*;
#(
    parameter int unsigned SE0_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic otg_bit,
    input  logic ms_tick,
    input  logic line_se0,
    input  logic bus_rst_det,
    output logic brst_ind
);

    localparam int unsigned SW = cnt_width(SE0_TICKS);

    logic [SW-1:0] se0_cnt;
    logic          fire;

    assign fire = line_se0 && ms_tick && (se0_cnt == SW'(SE0_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            se0_cnt  <= '0;
            brst_ind <= 1'b0;
        end else begin
            if (!line_se0)
                se0_cnt <= '0;
            else if (ms_tick && se0_cnt != SW'(SE0_TICKS))
                se0_cnt <= se0_cnt + 1'b1;
            brst_ind <= otg_bit ? fire : bus_rst_det;
        end
    end

endmodule

// File: rtl/srp_seq_top.sv
module srp_seq_top
    import srp_pkg::*;
#(
    parameter int unsigned INIT_TICKS = 2,
    parameter int unsigned DP_TICKS   = 5,
    parameter int unsigned VB_TICKS   = 10,
    parameter int unsigned TO_TICKS   = 20,
    parameter int unsigned SE0_TICKS  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic otg_bit,
    input  logic bsess_clr,
    input  logic ms_tick,
    input  logic dp_hi,
    input  logic dm_hi,
    input  logic sess_end,
    input  logic bsess_vld,
    input  logic bus_rst_det,
    output logic pullup_en,
    output logic vbus_pulse,
    output logic srp_busy,
    output logic srp_done,
    output logic srp_fail,
    output logic bsess_stat,
    output logic brst_ind
);

    sq_state_e  state;
    sq_result_t result;
    logic       line_se0;

    assign line_se0 = !dp_hi && !dm_hi;

    srp_fsm #(
        .INIT_TICKS(INIT_TICKS),
        .DP_TICKS  (DP_TICKS),
        .VB_TICKS  (VB_TICKS),
        .TO_TICKS  (TO_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .otg_bit  (otg_bit),
        .ms_tick  (ms_tick),
        .line_se0 (line_se0),
        .sess_end (sess_end),
        .bsess_vld(bsess_vld),
        .state    (state),
        .result   (result)
    );

    srp_sess_stat u_stat (
        .clk       (clk),
        .rst       (rst),
        .bsess_vld (bsess_vld),
        .bsess_clr (bsess_clr),
        .bsess_stat(bsess_stat)
    );

    srp_se0_watch #(
        .SE0_TICKS(SE0_TICKS)
    ) u_se0 (
        .clk        (clk),
        .rst        (rst),
        .otg_bit    (otg_bit),
        .ms_tick    (ms_tick),
        .line_se0   (line_se0),
        .bus_rst_det(bus_rst_det),
        .brst_ind   (brst_ind)
    );

    assign pullup_en  = (state == SQ_DPULSE);
    assign vbus_pulse = (state == SQ_VPULSE);
    assign srp_busy   = (state != SQ_IDLE);
    assign srp_done   = result.done;
    assign srp_fail   = result.fail;

endmodule

// File: rtl/srp_seq_checker.sv
module srp_seq_checker (
    input logic clk,
    input logic rst,
    input logic otg_bit,
    input logic bsess_vld,
    input logic bus_rst_det,
    input logic pullup_en,
    input logic vbus_pulse,
    input logic srp_busy,
    input logic srp_done,
    input logic srp_fail,
    input logic bsess_stat,
    input logic brst_ind
);

    AST_PULSES_APART: assert property (@(posedge clk) disable iff (rst)
        !(pullup_en && vbus_pulse)); // R4

    AST_VBUS_AFTER_DP: assert property (@(posedge clk) disable iff (rst)
        $rose(vbus_pulse) |-> $past(pullup_en)); // R4

    AST_DP_AFTER_CHECK: assert property (@(posedge clk) disable iff (rst)
        $rose(pullup_en) |-> $past(srp_busy)); // R2

    AST_DONE_NEEDS_SESS: assert property (@(posedge clk) disable iff (rst)
        $rose(srp_done) |-> $past(bsess_vld)); // R5

    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(srp_done && srp_fail)); // R6

    AST_STAT_SET: assert property (@(posedge clk) disable iff (rst)
        bsess_vld |=> bsess_stat); // R7

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (srp_busy && !otg_bit) |=> !srp_busy); // R10

    AST_BRST_LEGACY: assert property (@(posedge clk) disable iff (rst)
        !otg_bit |=> (brst_ind == $past(bus_rst_det))); // R8

endmodule

bind srp_seq_top srp_seq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .otg_bit    (otg_bit),
    .bsess_vld  (bsess_vld),
    .bus_rst_det(bus_rst_det),
    .pullup_en  (pullup_en),
    .vbus_pulse (vbus_pulse),
    .srp_busy   (srp_busy),
    .srp_done   (srp_done),
    .srp_fail   (srp_fail),
    .bsess_stat (bsess_stat),
    .brst_ind   (brst_ind)
);

// File: tb/srp_seq_top_test.sv
`timescale 1ns/1ps
module srp_seq_top_test;

    localparam int INIT_T = 2;
    localparam int DP_T   = 5;
    localparam int VB_T   = 10;
    localparam int TO_T   = 20;
    localparam int SE0_T  = 2;
    localparam int TDIV   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic otg_bit = 0, bsess_clr = 0, ms_tick = 0, dp_hi = 1, dm_hi = 0;
    logic sess_end = 0, bsess_vld = 0, bus_rst_det = 0;
    logic pullup_en, vbus_pulse, srp_busy, srp_done, srp_fail, bsess_stat, brst_ind;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    srp_seq_top #(
        .INIT_TICKS(INIT_T), .DP_TICKS(DP_T), .VB_TICKS(VB_T),
        .TO_TICKS(TO_T), .SE0_TICKS(SE0_T)
    ) uut (
        .clk(clk), .rst(rst), .otg_bit(otg_bit), .bsess_clr(bsess_clr),
        .ms_tick(ms_tick), .dp_hi(dp_hi), .dm_hi(dm_hi), .sess_end(sess_end),
        .bsess_vld(bsess_vld), .bus_rst_det(bus_rst_det),
        .pullup_en(pullup_en), .vbus_pulse(vbus_pulse), .srp_busy(srp_busy),
        .srp_done(srp_done), .srp_fail(srp_fail), .bsess_stat(bsess_stat),
        .brst_ind(brst_ind)
    );

    // Behavioural reference: phase 0 idle, 1 check, 2 D+ pulse, 3 VBUS pulse, 4 await
    int phase = 0, ticks = 0, se0_run = 0;
    bit otg_seen = 0, e_done = 0, e_fail = 0, e_stat = 0, e_brst = 0;

    always @(posedge clk) begin
        bit se0, fire, begin_req;
        if (rst) begin
            phase = 0; ticks = 0; se0_run = 0; otg_seen = 0;
            e_done = 0; e_fail = 0; e_stat = 0; e_brst = 0;
        end else begin
            se0 = !dp_hi && !dm_hi;
            fire = se0 && ms_tick && (se0_run == SE0_T - 1);
            e_brst = otg_bit ? fire : bus_rst_det;
            se0_run = !se0 ? 0 : ((ms_tick && se0_run < SE0_T) ? se0_run + 1 : se0_run);
            if (bsess_vld) e_stat = 1; else if (bsess_clr) e_stat = 0;
            begin_req = otg_bit && !otg_seen;
            otg_seen = otg_bit;
            if (phase != 0 && !otg_bit) begin
                phase = 0; ticks = 0;
            end else if (phase == 0) begin
                if (begin_req) begin phase = 1; ticks = 0; e_done = 0; e_fail = 0; end
            end else if (phase == 1) begin
                if (!(se0 && sess_end)) ticks = 0;
                else if (ms_tick) begin
                    ticks++;
                    if (ticks == INIT_T) begin phase = 2; ticks = 0; end
                end
            end else if (phase == 2 || phase == 3) begin
                if (ms_tick) begin
                    ticks++;
                    if (ticks == (phase == 2 ? DP_T : VB_T)) begin phase++; ticks = 0; end
                end
            end else begin
                if (bsess_vld) begin phase = 0; e_done = 1; end
                else if (ms_tick) begin
                    ticks++;
                    if (ticks == TO_T) begin phase = 0; e_fail = 1; end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R1 R10 srp_busy", srp_busy, phase != 0);
            chk("R2 R3 pullup_en", pullup_en, phase == 2);
            chk("R4 vbus_pulse", vbus_pulse, phase == 3);
            chk("R5 srp_done", srp_done, e_done);
            chk("R6 srp_fail", srp_fail, e_fail);
            chk("R7 bsess_stat", bsess_stat, e_stat);
            chk("R8 R9 brst_ind", brst_ind, e_brst);
        end
    end

    int tdiv_cnt = 0;
    always @(negedge clk) begin
        ms_tick <= (tdiv_cnt == TDIV - 1);
        tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        // R11: outputs quiet while held in reset
        chk("R11 reset outputs", |{pullup_en, vbus_pulse, srp_busy, srp_done,
                                   srp_fail, bsess_stat, brst_ind}, 1'b0);
        rst = 0;
        cyc(1);
        chk("R11 first cycle after reset", |{pullup_en, vbus_pulse, srp_busy, srp_done,
                                            srp_fail, bsess_stat, brst_ind}, 1'b0);
        // R8: legacy bus reset pass-through
        bus_rst_det = 1; cyc(1); bus_rst_det = 0; cyc(3);
        // R1 R2 R3 R4 R5: successful request with one broken idle check
        dp_hi = 0; sess_end = 1; otg_bit = 1;
        cyc(6); dp_hi = 1; cyc(1); dp_hi = 0;
        while (!vbus_pulse) cyc(1);
        while (vbus_pulse) cyc(1);
        cyc(10); bsess_vld = 1; cyc(2); bsess_vld = 0;
        cyc(4); otg_bit = 0; cyc(2);
        bsess_clr = 1; cyc(1); bsess_clr = 0; cyc(2);
        // R6: timeout, then retry clears flags, then R10 abort mid pulse
        otg_bit = 1; cyc(175);
        otg_bit = 0; cyc(2); otg_bit = 1;
        while (!pullup_en) cyc(1);
        cyc(3); otg_bit = 0; cyc(4);
        // R7: clear and valid in the same cycle
        bsess_vld = 1; cyc(2);
        bsess_clr = 1; cyc(1);
        bsess_vld = 0; cyc(1); bsess_clr = 0; cyc(2);
        bsess_clr = 1; cyc(1); bsess_clr = 0; cyc(2);
        // R9: OTG set, legacy detector ignored, SE0 timing fires once per run
        dp_hi = 1; sess_end = 0; otg_bit = 1; cyc(3);
        dp_hi = 0; cyc(2); bus_rst_det = 1; cyc(1); bus_rst_det = 0;
        cyc(25); dp_hi = 1; cyc(3); dp_hi = 0; cyc(14);
        otg_bit = 0; cyc(4);
        finish_run();
    end

endmodule